// File: doc/BRIEF.md
# Scrolling display address counter

This block keeps two base pointers that place a window of display digits over two memories: a 64-entry character memory and a 16-entry additional-data memory. While the display is scanned, the scanner presents a zero-based digit index (index 0 is the first digit). The block returns, combinationally, the read address of each memory for that digit. Each address is the matching base plus the index, wrapped to the memory size.

Decoded commands move the window. A load command sets both bases at once. A shift command moves the base of the character memory, the base of the additional-data memory, both, or neither, by one position. A right shift advances a base by one and a left shift steps it back by one. Both wrap around, so repeated shifts scroll the window in a circle over the memory.

Top module: `scroll_addr_ctr`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both bases are zero, so `char_addr` and `aux_addr` equal `digit_idx`.
- R2: `char_addr` equals the character base plus `digit_idx`, modulo 64.
- R3: `aux_addr` equals the additional-data base plus `digit_idx`, modulo 16.
- R4: A shift with `shift_left` = 0 (right) adds one to each selected base.
- R5: A shift with `shift_left` = 1 (left) subtracts one from each selected base.
- R6: A base whose select bit (`shift_main` for the character base, `shift_aux` for the additional-data base) is 0, or any base when `shift_en` is 0, keeps its value; a shift with neither select bit set changes nothing.
- R7: `load_en` loads `load_char_base` and `load_aux_base` together, and it wins over a shift given in the same cycle.
- R8: The bases wrap: a right shift of 3Fh gives 00h, a left shift of 00h gives 3Fh, and the additional-data base wraps likewise between Fh and 0h.
- R9: A command takes effect on the next rising clock edge. A change of `digit_idx` alone changes the addresses in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load both bases |
| load_char_base | input | 6 | New character base |
| load_aux_base | input | 4 | New additional-data base |
| shift_en | input | 1 | Shift strobe |
| shift_main | input | 1 | Shift applies to the character base |
| shift_aux | input | 1 | Shift applies to the additional-data base |
| shift_left | input | 1 | 1 = left (minus one), 0 = right (plus one) |
| digit_idx | input | 4 | Zero-based digit index from the scanner |
| char_addr | output | 6 | Character memory read address |
| aux_addr | output | 4 | Additional-data memory read address |

## Verification
The hardest states to reach are the wrap boundaries combined with selective shifting. These are a character base at 3Fh or 00h while the other base is in a different position and is not selected. Directed loads place the bases next to each boundary, and single-select shifts then cross it in each direction. Long random command streams with every index value follow, together with a load and a shift given in the same cycle. Within each cycle the index is also changed without a clock edge, to show the combinational path.

// File: rtl/scroll_addr_ctr.sv
module scroll_addr_ctr #(
  parameter int CHAR_AW = 6,
  parameter int AUX_AW  = 4,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [CHAR_AW-1:0] load_char_base,
  input  logic [AUX_AW-1:0]  load_aux_base,
  input  logic               shift_en,
  input  logic               shift_main,
  input  logic               shift_aux,
  input  logic               shift_left,
  input  logic [IDX_W-1:0]   digit_idx,
  output logic [CHAR_AW-1:0] char_addr,
  output logic [AUX_AW-1:0]  aux_addr
);

  localparam logic [CHAR_AW-1:0] CHAR_STEP = CHAR_AW'(1);
  localparam logic [AUX_AW-1:0]  AUX_STEP  = AUX_AW'(1);

  logic [CHAR_AW-1:0] char_base;
  logic [AUX_AW-1:0]  aux_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_base <= '0;
      aux_base  <= '0;
    end else if (load_en) begin
      char_base <= load_char_base;
      aux_base  <= load_aux_base;
    end else if (shift_en) begin
      if (shift_main)
        char_base <= shift_left ? char_base - CHAR_STEP : char_base + CHAR_STEP;
      if (shift_aux)
        aux_base <= shift_left ? aux_base - AUX_STEP : aux_base + AUX_STEP;
    end
  end

  assign char_addr = char_base + CHAR_AW'(digit_idx);
  assign aux_addr  = aux_base + AUX_AW'(digit_idx);

endmodule

// File: rtl/scroll_addr_ctr_chk.sv
module scroll_addr_ctr_chk #(
  parameter int CHAR_AW = 6,
  parameter int AUX_AW  = 4,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_en,
  input logic [CHAR_AW-1:0] load_char_base,
  input logic [AUX_AW-1:0]  load_aux_base,
  input logic               shift_en,
  input logic               shift_main,
  input logic               shift_aux,
  input logic               shift_left,
  input logic [IDX_W-1:0]   digit_idx,
  input logic [CHAR_AW-1:0] char_addr,
  input logic [AUX_AW-1:0]  aux_addr,
  input logic [CHAR_AW-1:0] char_base,
  input logic [AUX_AW-1:0]  aux_base
);

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (char_addr == CHAR_AW'(digit_idx) && aux_addr == AUX_AW'(digit_idx)));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_en)) |->
      (char_base == $past(load_char_base) && aux_base == $past(load_aux_base)));

  assert_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(shift_en) && !$past(load_en) && $past(shift_main) && !$past(shift_left))
      |-> char_base == CHAR_AW'($past(char_base) + 1'b1));

  assert_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(shift_en) && !$past(load_en) && $past(shift_aux) && $past(shift_left))
      |-> aux_base == AUX_AW'($past(aux_base) - 1'b1));

  assert_hold_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_en) && !($past(shift_en) && $past(shift_main)))
      |-> $stable(char_base));

  assert_hold_aux_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_en) && !($past(shift_en) && $past(shift_aux)))
      |-> $stable(aux_base));

endmodule

bind scroll_addr_ctr scroll_addr_ctr_chk #(
  .CHAR_AW(CHAR_AW), .AUX_AW(AUX_AW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en),
  .load_char_base(load_char_base), .load_aux_base(load_aux_base),
  .shift_en(shift_en), .shift_main(shift_main), .shift_aux(shift_aux),
  .shift_left(shift_left), .digit_idx(digit_idx),
  .char_addr(char_addr), .aux_addr(aux_addr),
  .char_base(char_base), .aux_base(aux_base)
);

// File: tb/tb_scroll_addr_ctr.sv
module tb_scroll_addr_ctr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [5:0] load_char_base = '0;
  logic [3:0] load_aux_base = '0;
  logic shift_en = 1'b0, shift_main = 1'b0, shift_aux = 1'b0, shift_left = 1'b0;
  logic [3:0] digit_idx = '0;
  logic [5:0] char_addr;
  logic [3:0] aux_addr;

  int checks = 0;
  int failures = 0;
  int mb = 0;
  int ab = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scroll_addr_ctr dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .load_char_base(load_char_base), .load_aux_base(load_aux_base),
    .shift_en(shift_en), .shift_main(shift_main), .shift_aux(shift_aux),
    .shift_left(shift_left), .digit_idx(digit_idx),
    .char_addr(char_addr), .aux_addr(aux_addr)
  );

  task automatic compare(input string tag);
    int ec, ea;
    ec = (mb + int'(digit_idx)) % 64;
    ea = (ab + int'(digit_idx)) % 16;
    checks++;
    if (int'(char_addr) != ec || int'(aux_addr) != ea) begin
      failures++;
      $display("FAIL %s idx=%0d char_addr=%0h exp=%0h aux_addr=%0h exp=%0h",
               tag, digit_idx, char_addr, ec, aux_addr, ea);
    end
  endtask

  // Drive one cycle, compare the state left by earlier cycles, then advance the model.
  task automatic step(input bit ld, input int lc, input int la, input bit sh,
                      input bit sm, input bit sa, input bit sl, input int idx,
                      input string tag);
    @(negedge clk);
    load_en = ld; load_char_base = 6'(lc); load_aux_base = 4'(la);
    shift_en = sh; shift_main = sm; shift_aux = sa; shift_left = sl;
    digit_idx = 4'(idx);
    #1 compare(tag);
    digit_idx = 4'(idx) ^ 4'h9;
    #1 compare("R9 index alone");
    digit_idx = 4'(idx);
    @(posedge clk);
    if (ld) begin
      mb = lc % 64; ab = la % 16;
    end else if (sh) begin
      if (sm) mb = sl ? (mb + 63) % 64 : (mb + 1) % 64;
      if (sa) ab = sl ? (ab + 15) % 16 : (ab + 1) % 16;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    digit_idx = 4'd5;
    #1 compare("R1 during reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0,  "R1 after release");
    step(0, 0, 0, 0, 0, 0, 0, 15, "R2 R3 base zero top digit");
    step(1, 'h3E, 'hE, 0, 0, 0, 0, 3, "R3 before load");
    step(0, 0, 0, 1, 1, 0, 0, 1,  "R7 load applied");
    step(0, 0, 0, 1, 1, 0, 0, 0,  "R4 right main to 3F, R6 aux held");
    step(0, 0, 0, 1, 0, 1, 1, 2,  "R8 main wraps 3F to 00");
    step(0, 0, 0, 1, 0, 0, 0, 7,  "R5 aux left");
    step(0, 0, 0, 0, 1, 1, 1, 4,  "R6 neither selected");
    step(1, 0, 0, 0, 0, 0, 0, 6,  "R6 shift_en low");
    step(0, 0, 0, 1, 1, 1, 1, 0,  "R7 load zero");
    step(0, 0, 0, 1, 1, 1, 0, 15, "R8 both wrap left to 3F and F");
    step(1, 'h10, 'h3, 1, 1, 1, 1, 9, "R4 both right back to zero");
    step(0, 0, 0, 0, 0, 0, 0, 12, "R7 load wins over shift");
    step(1, 'h3F, 'hF, 0, 0, 0, 0, 1, "R2 R3 after load");
    step(0, 0, 0, 1, 0, 1, 0, 15, "R2 R3 address wrap at 3F");
    step(0, 0, 0, 0, 0, 0, 0, 0,  "R8 aux wraps F to 0, R6 main held");
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 5, int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
           r >= 3 && r < 80, 1'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom_range(0, 15)), "R2 R3 R4 R5 random");
    end
    @(negedge clk);
    #1 compare("R2 R3 final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule